// File: doc/BRIEF.md
# Two-Wire Register Bank Slave with Time-Freeze Guard

This block is the serial front end for a bank of sixteen byte-wide timekeeping registers. A fast system clock samples the two bus lines. The block finds START, repeated START and STOP conditions and checks the 7-bit device address. When the address matches, it sets a register pointer from the next byte. It then writes the bytes that follow into the register bank, or, after a repeated START in read mode, sends register contents back to the master. It acknowledges every byte it accepts. The pointer steps by one after each data byte, so a master can move a full date/time record in one transfer.

The bank itself is outside this block. The block drives a register address, write data and a one-cycle write strobe, and it takes read data back combinationally for the addressed register. A freeze request is raised from START to STOP so that the counters in the timekeeping core hold still while a multi-byte record moves. A 1 Hz tick that arrives during the freeze is held and delivered once the freeze ends. A watchdog drops the freeze if a transfer stays open for longer than one second of system clock, so the clock cannot stay stopped.

Top module: `i2cRegSlave`

## Requirements
- R1: A START (SDA falling while SCL is high) raises `freezeReq`. A STOP (SDA rising while SCL is high) lowers it.
- R2: The first byte after START is the 7-bit device address, MSB first, followed by a direction bit (1 = read). The block acknowledges it by asserting `sdaOutEn` during the ninth SCL pulse only when the address equals `SLAVE_ADDR`. On a mismatch it neither acknowledges nor writes any register until the next START.
- R3: In write mode, the block loads the byte after the address into the pointer, using its low 4 bits. Each later byte is written to the register at the pointer with one `regWrEn` pulse. Every byte is acknowledged.
- R4: The pointer advances by one after every data byte that is written or read, and it wraps from 0x0F to 0x00.
- R5: After a repeated START with the read bit set, the block sends the register at the pointer MSB first. It sends another byte each time the master acknowledges. After a master NACK it releases SDA for the rest of the transfer.
- R6: After reset the pointer is 0, SDA is released and `freezeReq` is low.
- R7: If a transfer stays open for `WDOG_CYCLES` system clocks without a STOP, `freezeReq` falls while the transfer continues.
- R8: A `tickIn` pulse outside a freeze appears on `tickOut` one cycle later. A `tickIn` pulse during a freeze is held and appears exactly once on `tickOut` after the freeze ends.
- R9: `sdaOutEn` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOutEn | output | 1 | 1 pulls SDA low, 0 releases it |
| regAddr | output | 4 | Register pointer, addresses the bank |
| regWrData | output | 8 | Byte to write into the bank |
| regWrEn | output | 1 | One-cycle write strobe to the bank |
| regRdData | input | 8 | Bank contents at `regAddr` |
| tickIn | input | 1 | 1 Hz tick from the prescaler |
| tickOut | output | 1 | Tick passed on to the time counters |
| freezeReq | output | 1 | Hold request for the time counters |

## Verification
Several properties are checked on every cycle by assertions in the RTL: SDA is only switched while SCL is low, a pointer load takes the received byte, the pointer wraps at the top of the bank, write strobes last a single cycle, and the freeze is released after a STOP. Only the bench scenarios can show the whole-byte behaviour. These cover address filtering with a wrong address, data streaming across the wrap point, the read after a repeated START ending on a NACK, the held tick arriving after STOP, and the watchdog ending a transfer that is left open.

// File: rtl/i2cSlavePkg.sv
package i2cSlavePkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } busState_t;

  typedef enum logic [1:0] {
    RX_ADDR,
    RX_PTR,
    RX_DATA
  } rxKind_t;

  typedef struct packed {
    logic rxShift;
    logic rxBit;
    logic ptrLoad;
    logic ptrInc;
    logic regWrite;
    logic txLoad;
    logic txShift;
  } dpStrobe_t;
endpackage

// File: rtl/i2cBusCtrl.sv
module i2cBusCtrl
  import i2cSlavePkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h51,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  output dpStrobe_t         strb,
  output logic              sdaOutEn,
  output logic              startDet,
  output logic              stopDet
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclP, sdaP, sclS, sdaS, sclRise, sclFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclP  <= 1'b1;
      sdaP  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclP  <= sclS;
      sdaP  <= sdaS;
    end
  end

  assign sclS     = sclSh[SYNC_STAGES-1];
  assign sdaS     = sdaSh[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclP;
  assign sclFall  = ~sclS & sclP;
  assign startDet = sclS & sclP & sdaP & ~sdaS;
  assign stopDet  = sclS & sclP & ~sdaP & sdaS;

  busState_t       state, stateN;
  rxKind_t         kind, kindN;
  logic [CNT_W-1:0] cnt, cntN;
  logic            rdMode, rdModeN, masterAck, masterAckN;

  always_comb begin
    stateN     = state;
    kindN      = kind;
    cntN       = cnt;
    rdModeN    = rdMode;
    masterAckN = masterAck;
    strb       = '0;
    strb.rxBit = sdaS;
    if (stopDet) begin
      stateN = ST_IDLE;
    end else if (startDet) begin
      stateN = ST_RX;
      kindN  = RX_ADDR;
      cntN   = '0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && cnt < FULL) begin
            strb.rxShift = 1'b1;
            cntN = cnt + 1'b1;
          end else if (sclFall && cnt == FULL) begin
            case (kind)
              RX_ADDR: begin
                if (rxByte[BYTE_W-1:1] == SLAVE_ADDR) begin
                  stateN  = ST_ACK;
                  rdModeN = rxByte[0];
                end else begin
                  stateN = ST_IDLE;
                end
              end
              RX_PTR: begin
                stateN = ST_ACK;
                strb.ptrLoad = 1'b1;
              end
              default: begin
                stateN = ST_ACK;
                strb.regWrite = 1'b1;
                strb.ptrInc   = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            cntN = '0;
            if (kind == RX_ADDR && rdMode) begin
              stateN = ST_TX;
              strb.txLoad = 1'b1;
            end else begin
              stateN = ST_RX;
              kindN  = (kind == RX_ADDR) ? RX_PTR : RX_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (cnt == LAST) begin
              stateN = ST_MACK;
              strb.ptrInc = 1'b1;
            end else begin
              strb.txShift = 1'b1;
              cntN = cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            masterAckN = ~sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              stateN = ST_TX;
              strb.txLoad = 1'b1;
              cntN = '0;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= RX_ADDR;
      cnt       <= '0;
      rdMode    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateN;
      kind      <= kindN;
      cnt       <= cntN;
      rdMode    <= rdModeN;
      masterAck <= masterAckN;
    end
  end

  assign sdaOutEn = (state == ST_ACK) | ((state == ST_TX) & ~txBit);

  // R9
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOutEn) |-> !sclS);

  // R1
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE) && !sdaOutEn);
endmodule

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cSlavePkg::*;
#(
  parameter int REG_COUNT = 16,
  localparam int ADDR_W = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [BYTE_W-1:0] regRdData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn
);
  localparam logic [ADDR_W-1:0] PTR_MAX = ADDR_W'(REG_COUNT - 1);

  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] txSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr    <= '0;
      rxByte <= '0;
      txSh   <= '0;
    end else begin
      if (strb.rxShift) rxByte <= {rxByte[BYTE_W-2:0], strb.rxBit};
      if (strb.ptrLoad) ptr <= rxByte[ADDR_W-1:0];
      else if (strb.ptrInc) ptr <= (ptr == PTR_MAX) ? '0 : ptr + 1'b1;
      if (strb.txLoad) txSh <= regRdData;
      else if (strb.txShift) txSh <= {txSh[BYTE_W-2:0], 1'b0};
    end
  end

  assign txBit     = txSh[BYTE_W-1];
  assign regAddr   = ptr;
  assign regWrData = rxByte;
  assign regWrEn   = strb.regWrite;

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.ptrInc) && !$past(strb.ptrLoad) && $past(regAddr) == PTR_MAX |-> regAddr == '0);

  // R3
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrLoad |=> regAddr == $past(rxByte[ADDR_W-1:0]));

  // R3
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);
endmodule

// File: rtl/i2cFreezeWdog.sv
module i2cFreezeWdog #(
  parameter int WDOG_CYCLES = 100_000_000,
  localparam int WD_W = $clog2(WDOG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic startDet,
  input  logic stopDet,
  input  logic tickIn,
  output logic freezeReq,
  output logic tickOut
);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_CYCLES - 1);

  logic            inXfer, expired, pending;
  logic [WD_W-1:0] wdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inXfer  <= 1'b0;
      expired <= 1'b0;
      wdCnt   <= '0;
    end else if (startDet) begin
      inXfer  <= 1'b1;
      expired <= 1'b0;
      wdCnt   <= '0;
    end else if (stopDet) begin
      inXfer  <= 1'b0;
      expired <= 1'b0;
      wdCnt   <= '0;
    end else if (inXfer && !expired) begin
      if (wdCnt == WD_LAST) expired <= 1'b1;
      else wdCnt <= wdCnt + 1'b1;
    end
  end

  assign freezeReq = inXfer & ~expired;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      tickOut <= 1'b0;
    end else begin
      pending <= freezeReq & (pending | tickIn);
      tickOut <= ~freezeReq & (pending | tickIn);
    end
  end

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !freezeReq);

  // R7
  wd_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    freezeReq |-> wdCnt <= WD_LAST);
endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cSlavePkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h51,
  parameter int         REG_COUNT   = 16,
  parameter int         WDOG_CYCLES = 100_000_000,
  localparam int        ADDR_W      = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOutEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regWrEn,
  input  logic [BYTE_W-1:0] regRdData,
  input  logic              tickIn,
  output logic              tickOut,
  output logic              freezeReq
);
  dpStrobe_t         strb;
  logic [BYTE_W-1:0] rxByte;
  logic              txBit, startDet, stopDet;

  i2cBusCtrl #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_STAGES(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxByte(rxByte), .txBit(txBit), .strb(strb), .sdaOutEn(sdaOutEn),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cRegDatapath #(.REG_COUNT(REG_COUNT)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regRdData(regRdData),
    .rxByte(rxByte), .txBit(txBit), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn)
  );

  i2cFreezeWdog #(.WDOG_CYCLES(WDOG_CYCLES)) i_frz (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .tickIn(tickIn), .freezeReq(freezeReq), .tickOut(tickOut)
  );
endmodule

// File: tb/test_i2cRegSlave.sv
module test_i2cRegSlave;
  localparam logic [6:0] DEV = 7'h51;
  localparam int WDOG = 5000;
  localparam int Q = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, tickIn = 1'b0;
  logic sdaOutEn, regWrEn, tickOut, freezeReq;
  logic [3:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] coreRegs [16];
  logic sdaBus;

  int checks = 0, errors = 0, wrCount = 0, tickCount = 0, r9Bad = 0;
  bit done = 0;
  logic [11:0] wrQueue [$];
  logic prevOe = 1'b0;

  always #5 clk = ~clk;
  assign sdaBus = sdaM & ~sdaOutEn;
  assign regRdData = coreRegs[regAddr];

  i2cRegSlave #(.SLAVE_ADDR(DEV), .REG_COUNT(16), .WDOG_CYCLES(WDOG)) i_i2cRegSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOutEn(sdaOutEn),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData), .tickIn(tickIn), .tickOut(tickOut), .freezeReq(freezeReq)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) coreRegs[i] <= 8'(8'h11 * i + 3);
    end else if (regWrEn) begin
      coreRegs[regAddr] <= regWrData;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected register writes and compares
  always @(negedge clk) begin
    if (rstN) begin
      if (regWrEn) begin
        wrCount++;
        if (wrQueue.size() == 0) check(0, "R2/R3 unexpected write", {regAddr, regWrData}, 0);
        else begin
          logic [11:0] e;
          e = wrQueue.pop_front();
          check({regAddr, regWrData} == e, "R3 write", {regAddr, regWrData}, e);
        end
      end
      if (tickOut) tickCount++;
      if (sdaOutEn != prevOe && sclM) r9Bad++;
      prevOe = sdaOutEn;
    end
  end

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart;
    sdaM = 1'b1; waitQ; sclM = 1'b1; waitQ; sdaM = 1'b0; waitQ; sclM = 1'b0; waitQ;
  endtask

  task automatic busStop;
    sdaM = 1'b0; waitQ; sclM = 1'b1; waitQ; sdaM = 1'b1; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ; sclM = 1'b1; waitQ; waitQ; sclM = 1'b0; waitQ;
    end
    sdaM = 1'b1; waitQ; sclM = 1'b1; waitQ; ack = ~sdaBus; waitQ; sclM = 1'b0; waitQ;
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ; sclM = 1'b1; waitQ; b[i] = sdaBus; waitQ; sclM = 1'b0; waitQ;
    end
    sdaM = ~giveAck; waitQ; sclM = 1'b1; waitQ; waitQ; sclM = 1'b0; waitQ;
    sdaM = 1'b1;
  endtask

  task automatic putByte(input logic [7:0] b, input string req);
    bit ack;
    sendByte(b, ack);
    check(ack, req, ack, 1);
  endtask

  task automatic getByte(input bit giveAck, input logic [7:0] exp, input string req);
    logic [7:0] b;
    recvByte(giveAck, b);
    check(b == exp, req, b, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    bit ack;
    repeat (10) @(negedge clk);
    // R6 reset state
    check(sdaOutEn == 0, "R6 sda released", sdaOutEn, 0);
    check(freezeReq == 0, "R6 freeze low", freezeReq, 0);
    check(regAddr == 0, "R6 pointer zero", regAddr, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R6: read with no pointer set returns register 0
    busStart;
    putByte({DEV, 1'b1}, "R2 read address ack");
    getByte(0, 8'h03, "R6 first read at pointer 0");
    busStop;

    // R3/R4 write stream, R1 freeze
    busStart;
    putByte({DEV, 1'b0}, "R2 write address ack");
    check(freezeReq == 1, "R1 freeze during transfer", freezeReq, 1);
    putByte(8'h02, "R3 pointer byte ack");
    wrQueue.push_back({4'h2, 8'hA5});
    putByte(8'hA5, "R3 data ack");
    wrQueue.push_back({4'h3, 8'h3C});
    putByte(8'h3C, "R3 data ack");
    busStop;
    repeat (5) @(negedge clk);
    check(freezeReq == 0, "R1 freeze released by stop", freezeReq, 0);
    check(wrQueue.size() == 0, "R3 all writes seen", wrQueue.size(), 0);

    // R5 read after repeated start
    busStart;
    putByte({DEV, 1'b0}, "R2 address ack");
    putByte(8'h02, "R3 pointer ack");
    busStart;
    putByte({DEV, 1'b1}, "R5 read address ack");
    getByte(1, 8'hA5, "R5 read byte 0");
    getByte(1, 8'h3C, "R4 read advances pointer");
    getByte(0, 8'h47, "R5 read last byte");
    waitQ;
    check(sdaOutEn == 0, "R5 released after nack", sdaOutEn, 0);
    busStop;

    // R4 wrap on writes and reads
    busStart;
    putByte({DEV, 1'b0}, "R2 address ack");
    putByte(8'h0F, "R3 pointer ack");
    wrQueue.push_back({4'hF, 8'h99});
    putByte(8'h99, "R3 data ack");
    wrQueue.push_back({4'h0, 8'h66});
    putByte(8'h66, "R4 write after wrap ack");
    busStop;
    busStart;
    putByte({DEV, 1'b0}, "R2 address ack");
    putByte(8'h0F, "R3 pointer ack");
    busStart;
    putByte({DEV, 1'b1}, "R5 read address ack");
    getByte(1, 8'h99, "R4 read top register");
    getByte(0, 8'h66, "R4 read wraps to 0");
    busStop;

    // R2 mismatched address
    base = wrCount;
    busStart;
    sendByte({DEV ^ 7'h01, 1'b0}, ack);
    check(ack == 0, "R2 no ack on foreign address", ack, 0);
    sendByte(8'h05, ack);
    sendByte(8'h77, ack);
    check(ack == 0, "R2 no ack on ignored data", ack, 0);
    busStop;
    check(wrCount == base, "R2 no write on foreign address", wrCount, base);

    // R8 tick handling
    base = tickCount;
    @(negedge clk); tickIn = 1'b1; @(negedge clk); tickIn = 1'b0;
    repeat (3) @(negedge clk);
    check(tickCount == base + 1, "R8 tick passes when idle", tickCount, base + 1);
    busStart;
    putByte({DEV, 1'b0}, "R2 address ack");
    @(negedge clk); tickIn = 1'b1; @(negedge clk); tickIn = 1'b0;
    repeat (50) @(negedge clk);
    check(tickCount == base + 1, "R8 tick held during freeze", tickCount, base + 1);
    busStop;
    repeat (10) @(negedge clk);
    check(tickCount == base + 2, "R8 held tick delivered once", tickCount, base + 2);

    // R7 watchdog
    busStart;
    putByte({DEV, 1'b0}, "R2 address ack");
    check(freezeReq == 1, "R7 frozen before timeout", freezeReq, 1);
    repeat (WDOG + 100) @(negedge clk);
    check(freezeReq == 0, "R7 watchdog ends freeze", freezeReq, 0);
    busStop;

    check(r9Bad == 0, "R9 sda changes only with scl low", r9Bad, 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule